// File: doc/BRIEF.md
# Password-Gated Audio Controller Configuration Bank

This block is the configuration front end of a multi-function ISA audio controller. It holds six 8-bit setup registers at six consecutive host I/O ports, starting at 0xF8D. Register index 0 sits at 0xF8D and index 5 at 0xF92. The host cannot reach a register directly. It first writes the controller's identity byte (parameter `CHIP_ID`, default 0xE3) to the key port 0xF8F, which is register index 2. That single write opens the bank for exactly one read or one write to any of the six ports. After that access the bank closes again.

The stored values are decoded into the resources the rest of the controller uses. These are the legacy sound block's base, DMA channel and IRQ line, the codec-mode switch with its window base, the game-port enable, and the MIDI port's base and IRQ. The legacy resources live in their own holding registers. They reload only when a write gives the legacy register a new value.

The host bus is a plain strobe bus: `host_wr` or `host_rd` is held for one clock together with the address. Read data is registered and appears in `host_rdata` after the clock edge that samples the read strobe. It holds until the next read inside the window. If both strobes are high together, only the write is performed.

Top module: `acfg_bank`

## Requirements
- R1: After reset the register values at indices 0..5 are 0x00, 0x03, 0x00, 0x00, 0x3F, 0x83. The outputs show legacy base 0x220, IRQ 5, DMA 1, MIDI base 0x330, MIDI IRQ 9, codec base 0x530, codec mode off, game port on, and `host_rdata` = 0xFF.
- R2: While the bank is closed, a read of any of the six ports returns 0xFF and a write to any of them changes no register.
- R3: A write of `CHIP_ID` to port 0xF8F opens the bank. The next read or write inside the six-port window takes effect and closes it, so a second access returns 0xFF or is dropped.
- R4: A permitted read of index 2 returns the stored value with bits 1:0 replaced by binary 10.
- R5: A permitted write of `CHIP_ID` to index 2 does not store. Because it is also a key write, it reopens the bank for one access in the same cycle.
- R6: Index 0 bit 7 drives `codec_mode`. Bits 5:4 pick `codec_base` 0→0x530, 1→0xE80, 2→0xF40, 3→0x604. Bit 0 set clears `game_en`.
- R7: A stored write to index 2 with a value different from the current one reloads the legacy outputs. Bit 2 gives base 0x240 when set and 0x220 when clear. Bits 5:4 give DMA 0→1, 1→0, else 3. Bits 7:6 give IRQ 0→7, 1→10, else 5. A write of the current value leaves the legacy outputs unchanged.
- R8: Index 5 bits 4:3 pick `midi_irq` 0→9, 1→10, 2→5, 3→7. Bits 6:5 pick `midi_base` 0→0x330, 1→0x320, 2→0x310, 3→0x300.
- R9: Three writes to 0xF8F of `CHIP_ID`, 0x00, `CHIP_ID` force index 2 to 0x02 on the third write, whether or not the bank is open. The legacy outputs do not change.
- R10: A read or write at a port outside the six-port window neither uses up an open bank nor changes any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 16 | I/O port address |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| codec_mode | output | 1 | Codec mode selected instead of legacy mode |
| codec_base | output | 16 | Codec window base port |
| game_en | output | 1 | Game port at 0x200 enabled |
| legacy_base | output | 16 | Legacy sound block base port |
| legacy_dma | output | 2 | Legacy DMA channel |
| legacy_irq | output | 4 | Legacy IRQ line |
| midi_base | output | 16 | MIDI port base |
| midi_irq | output | 4 | MIDI IRQ line |

## Verification
A write of the identity byte to the key port while the bank is already open does two things in one edge. It uses up the open access as a register write to index 2, and it reopens the bank as a key write. The bench provokes this by opening the bank and then writing the identity byte to 0xF8F. It then reads 0xF8F without a fresh key write and expects the old contents with bits 1:0 reading as 10, followed by 0xFF on a second read. In the same way, the third write of the forcing sequence both sets index 2 to 0x02 and opens the bank. This is judged by reading 0x02 back with no additional key write and by seeing the legacy outputs stay unchanged.

// File: rtl/acfg_pkg.sv
package acfg_pkg;

  localparam int unsigned DW         = 8;
  localparam int unsigned IDX_MODE   = 0;
  localparam int unsigned IDX_LEGACY = 2;
  localparam int unsigned IDX_MIDI   = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ID   = 2'd1,
    SEQ_ZERO = 2'd2
  } seq_e;

  typedef struct packed {
    logic [15:0] base;
    logic [1:0]  dma;
    logic [3:0]  irq;
  } legacy_res_t;

  function automatic logic [DW-1:0] reg_reset(input int unsigned idx);
    case (idx)
      1:       return 8'h03;
      4:       return 8'h3F;
      5:       return 8'h83;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] codec_base_f(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16'h0530;
      2'd1:    return 16'h0E80;
      2'd2:    return 16'h0F40;
      default: return 16'h0604;
    endcase
  endfunction

  function automatic logic [15:0] midi_base_f(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16'h0330;
      2'd1:    return 16'h0320;
      2'd2:    return 16'h0310;
      default: return 16'h0300;
    endcase
  endfunction

  function automatic logic [3:0] midi_irq_f(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd9;
      2'd1:    return 4'd10;
      2'd2:    return 4'd5;
      default: return 4'd7;
    endcase
  endfunction

  function automatic legacy_res_t legacy_f(input logic [DW-1:0] v);
    legacy_res_t r;
    r.base = v[2] ? 16'h0240 : 16'h0220;
    case (v[5:4])
      2'd0:    r.dma = 2'd1;
      2'd1:    r.dma = 2'd0;
      default: r.dma = 2'd3;
    endcase
    case (v[7:6])
      2'd0:    r.irq = 4'd7;
      2'd1:    r.irq = 4'd10;
      default: r.irq = 4'd5;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/acfg_gate.sv
module acfg_gate
  import acfg_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter logic [15:0] BASE    = 16'h0F8D,
  parameter int unsigned NREG    = 6,
  parameter int unsigned KEY_IDX = 2,
  parameter logic [7:0]  CHIP_ID = 8'hE3,
  localparam int unsigned IW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic          unlocked,
  output logic [IW-1:0] idx,
  output logic          reg_we,
  output logic          reg_rd,
  output logic          force_key
);

  logic [AW-1:0] off;
  logic          in_range;
  logic          wr_hit;
  logic          rd_hit;
  logic          key_wr;
  logic          arm;
  logic          unlock_q;
  seq_e          seq_q;

  assign off      = host_addr - AW'(BASE);
  assign in_range = off < AW'(NREG);
  assign idx      = off[IW-1:0];
  assign wr_hit   = host_wr && in_range;
  assign rd_hit   = host_rd && !host_wr && in_range;
  assign key_wr   = host_wr && (host_addr == AW'(BASE) + AW'(KEY_IDX));
  assign arm      = key_wr && (host_wdata == CHIP_ID);

  // The key write of the identity byte is never stored in the key register.
  assign reg_we    = wr_hit && unlock_q && !arm;
  assign reg_rd    = rd_hit;
  assign unlocked  = unlock_q;
  assign force_key = arm && (seq_q == SEQ_ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_q <= 1'b0;
    end else if (arm) begin
      unlock_q <= 1'b1;
    end else if (wr_hit || rd_hit) begin
      unlock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q <= SEQ_IDLE;
    end else if (key_wr) begin
      if (host_wdata == CHIP_ID) begin
        seq_q <= SEQ_ID;
      end else if (host_wdata == '0) begin
        seq_q <= (seq_q == SEQ_ID) ? SEQ_ZERO : SEQ_IDLE;
      end else begin
        seq_q <= SEQ_IDLE;
      end
    end
  end

  // R3: an access inside the window without a fresh key closes the bank
  p_one_access_r3: assert property (@(posedge clk) disable iff (rst)
    (((host_wr || host_rd) && in_range) && !(host_wr && host_addr == AW'(BASE) + AW'(KEY_IDX)
      && host_wdata == CHIP_ID)) |=> !unlocked);

  // R3: the key write always leaves the bank open
  p_key_opens_r3: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == AW'(BASE) + AW'(KEY_IDX) && host_wdata == CHIP_ID) |=> unlocked);

  // R10: activity outside the window keeps the lock state
  p_outside_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (!in_range && !key_wr) |=> $stable(unlocked));

endmodule

// File: rtl/acfg_store.sv
module acfg_store
  import acfg_pkg::*;
#(
  parameter int unsigned NREG    = 6,
  parameter int unsigned KEY_IDX = 2,
  localparam int unsigned IW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] idx,
  input  logic          reg_we,
  input  logic          reg_rd,
  input  logic          unlocked,
  input  logic          force_key,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] mode_reg,
  output logic [DW-1:0] legacy_reg,
  output logic [DW-1:0] midi_reg
);

  logic [DW-1:0] q [NREG];
  logic [DW-1:0] rd_val;
  logic [DW-1:0] rdata_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= reg_reset(i);
      end else if (force_key && (i == KEY_IDX)) begin
        q[i] <= 8'h02;
      end else if (reg_we && (idx == IW'(i))) begin
        q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rd_val = 8'hFF;
    if (unlocked) begin
      rd_val = q[idx];
      if (idx == IW'(KEY_IDX)) begin
        rd_val = {q[idx][DW-1:2], 2'b10};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= 8'hFF;
    end else if (reg_rd) begin
      rdata_q <= rd_val;
    end
  end

  assign rdata      = rdata_q;
  assign mode_reg   = q[IDX_MODE];
  assign legacy_reg = q[IDX_LEGACY];
  assign midi_reg   = q[IDX_MIDI];

  // R2: a closed bank answers reads with all ones
  p_closed_read_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !unlocked) |=> (rdata == 8'hFF));

  // R4: the key register always reads back with its low pair as binary 10
  p_key_low_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && unlocked && idx == IW'(KEY_IDX)) |=> (rdata[1:0] == 2'b10));

  // R2: with neither a permitted write nor a force, the stored set holds
  p_closed_write_r2: assert property (@(posedge clk) disable iff (rst)
    (!reg_we && !force_key) |=> ($stable(mode_reg) && $stable(legacy_reg) && $stable(midi_reg)));

  // R9: the completed sequence leaves 0x02 in the key register
  p_force_value_r9: assert property (@(posedge clk) disable iff (rst)
    force_key |=> (legacy_reg == 8'h02));

endmodule

// File: rtl/acfg_legacy.sv
module acfg_legacy
  import acfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cur,
  output legacy_res_t   res
);

  legacy_res_t res_q;
  logic        load;

  // Reload only on a real change, so the reset resources survive a rewrite of 0x00.
  assign load = we && (wdata != cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q.base <= 16'h0220;
      res_q.dma  <= 2'd1;
      res_q.irq  <= 4'd5;
    end else if (load) begin
      res_q <= legacy_f(wdata);
    end
  end

  assign res = res_q;

  // R7: resources move only on a stored write to the legacy register
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(res));

  // R7: rewriting the present value keeps the resources
  p_same_value_r7: assert property (@(posedge clk) disable iff (rst)
    (we && wdata == cur) |=> $stable(res));

endmodule

// File: rtl/acfg_decode.sv
module acfg_decode
  import acfg_pkg::*;
(
  input  logic [DW-1:0] mode_reg,
  input  logic [DW-1:0] midi_reg,
  output logic          codec_mode,
  output logic [15:0]   codec_base,
  output logic          game_en,
  output logic [15:0]   midi_base,
  output logic [3:0]    midi_irq
);

  always_comb begin
    codec_mode = mode_reg[7];
    codec_base = codec_base_f(mode_reg[5:4]);
    game_en    = !mode_reg[0];
    midi_base  = midi_base_f(midi_reg[6:5]);
    midi_irq   = midi_irq_f(midi_reg[4:3]);
  end

endmodule

// File: rtl/acfg_bank.sv
module acfg_bank
  import acfg_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter logic [15:0] BASE    = 16'h0F8D,
  parameter int unsigned NREG    = 6,
  parameter logic [7:0]  CHIP_ID = 8'hE3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          codec_mode,
  output logic [15:0]   codec_base,
  output logic          game_en,
  output logic [15:0]   legacy_base,
  output logic [1:0]    legacy_dma,
  output logic [3:0]    legacy_irq,
  output logic [15:0]   midi_base,
  output logic [3:0]    midi_irq
);

  localparam int unsigned IW      = $clog2(NREG);
  localparam int unsigned KEY_IDX = IDX_LEGACY;

  logic          unlocked;
  logic [IW-1:0] idx;
  logic          reg_we;
  logic          reg_rd;
  logic          force_key;
  logic [DW-1:0] mode_reg;
  logic [DW-1:0] legacy_reg;
  logic [DW-1:0] midi_reg;
  legacy_res_t   lres;

  acfg_gate #(
    .AW(AW), .BASE(BASE), .NREG(NREG), .KEY_IDX(KEY_IDX), .CHIP_ID(CHIP_ID)
  ) u_gate (
    .clk(clk), .rst(rst), .host_addr(host_addr[AW-1:0]), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .unlocked(unlocked), .idx(idx),
    .reg_we(reg_we), .reg_rd(reg_rd), .force_key(force_key)
  );

  acfg_store #(.NREG(NREG), .KEY_IDX(KEY_IDX)) u_store (
    .clk(clk), .rst(rst), .idx(idx), .reg_we(reg_we), .reg_rd(reg_rd),
    .unlocked(unlocked), .force_key(force_key), .wdata(host_wdata),
    .rdata(host_rdata), .mode_reg(mode_reg), .legacy_reg(legacy_reg), .midi_reg(midi_reg)
  );

  acfg_legacy u_legacy (
    .clk(clk), .rst(rst), .we(reg_we && (idx == IW'(IDX_LEGACY))),
    .wdata(host_wdata), .cur(legacy_reg), .res(lres)
  );

  acfg_decode u_decode (
    .mode_reg(mode_reg), .midi_reg(midi_reg), .codec_mode(codec_mode),
    .codec_base(codec_base), .game_en(game_en), .midi_base(midi_base), .midi_irq(midi_irq)
  );

  assign legacy_base = lres.base;
  assign legacy_dma  = lres.dma;
  assign legacy_irq  = lres.irq;

  // R9: the forcing write never moves the legacy resources
  p_force_keeps_res_r9: assert property (@(posedge clk) disable iff (rst)
    force_key |=> ($stable(legacy_base) && $stable(legacy_dma) && $stable(legacy_irq)));

endmodule

// File: tb/sim_acfg_bank.sv
module sim_acfg_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] host_addr = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        codec_mode;
  logic [15:0] codec_base;
  logic        game_en;
  logic [15:0] legacy_base;
  logic [1:0]  legacy_dma;
  logic [3:0]  legacy_irq;
  logic [15:0] midi_base;
  logic [3:0]  midi_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  acfg_bank u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .codec_mode(codec_mode),
    .codec_base(codec_base), .game_en(game_en), .legacy_base(legacy_base),
    .legacy_dma(legacy_dma), .legacy_irq(legacy_irq), .midi_base(midi_base),
    .midi_irq(midi_irq)
  );

  localparam logic [15:0] KEY = 16'h0F8F;
  localparam logic [7:0]  ID  = 8'hE3;
  localparam logic [3:0]  OW  = 4'd1;
  localparam logic [3:0]  OR  = 4'd2;
  localparam int NV = 28;
  // {op, requirement, address, write data, expected read data}
  localparam logic [39:0] VEC [NV] = '{
    {OR, 4'd2, 16'h0F8D, 8'h00, 8'hFF},  // R2 closed read
    {OW, 4'd2, 16'h0F8D, 8'h55, 8'h00},  // R2 closed write
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OR, 4'd1, 16'h0F8D, 8'h00, 8'h00},  // R1 index 0, R2 write dropped
    {OR, 4'd3, 16'h0F8D, 8'h00, 8'hFF},  // R3 closed again
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OR, 4'd1, 16'h0F8E, 8'h00, 8'h03},  // R1 index 1
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OR, 4'd1, 16'h0F90, 8'h00, 8'h00},  // R1 index 3
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OR, 4'd1, 16'h0F91, 8'h00, 8'h3F},  // R1 index 4
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OR, 4'd1, 16'h0F92, 8'h00, 8'h83},  // R1 index 5
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OR, 4'd4, KEY,      8'h00, 8'h02},  // R4 reset key register
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OW, 4'd3, 16'h0F8E, 8'hA5, 8'h00},
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OR, 4'd3, 16'h0F8E, 8'h00, 8'hA5},  // R3 write took effect
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OW, 4'd4, KEY,      8'hCC, 8'h00},
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OR, 4'd4, KEY,      8'h00, 8'hCE},  // R4 low bits forced
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OW, 4'd3, 16'h0F90, 8'h11, 8'h00},
    {OW, 4'd2, 16'h0F90, 8'h22, 8'h00},  // R2 second write dropped
    {OW, 4'd3, KEY,      ID,    8'h00},
    {OR, 4'd2, 16'h0F90, 8'h00, 8'h11}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic legacy_chk(input string req, input logic [15:0] b, input logic [1:0] d,
                            input logic [3:0] q);
    check({req, " legacy base"}, 32'(legacy_base), 32'(b));
    check({req, " legacy dma"}, 32'(legacy_dma), 32'(d));
    check({req, " legacy irq"}, 32'(legacy_irq), 32'(q));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset outputs
    check("R1 rdata", 32'(host_rdata), 32'hFF);
    legacy_chk("R1", 16'h0220, 2'd1, 4'd5);
    check("R1 midi base", 32'(midi_base), 32'h330);
    check("R1 midi irq", 32'(midi_irq), 32'd9);
    check("R1 codec base", 32'(codec_base), 32'h530);
    check("R1 codec mode", 32'(codec_mode), 32'd0);
    check("R1 game", 32'(game_en), 32'd1);

    // R7 rewriting the present value 0x00 keeps reset resources
    wr(KEY, ID); wr(KEY, 8'h00);
    legacy_chk("R7 same value", 16'h0220, 2'd1, 4'd5);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][39:36] == OW) begin
        wr(VEC[i][31:16], VEC[i][15:8]);
      end else begin
        rd(VEC[i][31:16]);
        check($sformatf("R%0d vector %0d", VEC[i][35:32], i), 32'(host_rdata), 32'(VEC[i][7:0]));
      end
    end
    // R7 0xCC stored above: base 0x240, DMA 1, IRQ 5
    legacy_chk("R7 cc", 16'h0240, 2'd1, 4'd5);
    wr(KEY, ID); wr(KEY, 8'h54);
    legacy_chk("R7 54", 16'h0240, 2'd0, 4'd10);
    wr(KEY, ID); wr(KEY, 8'h20);
    legacy_chk("R7 20", 16'h0220, 2'd3, 4'd7);

    // R5 identity byte written while open: not stored, bank reopened
    wr(KEY, ID); wr(KEY, ID);
    rd(KEY);
    check("R5 reopened read", 32'(host_rdata), 32'h22);
    rd(KEY);
    check("R5 single access", 32'(host_rdata), 32'hFF);

    // R6 mode register decode
    wr(KEY, ID); wr(16'h0F8D, 8'hB1);
    check("R6 mode", 32'(codec_mode), 32'd1);
    check("R6 base", 32'(codec_base), 32'h604);
    check("R6 game", 32'(game_en), 32'd0);
    wr(KEY, ID); wr(16'h0F8D, 8'h20);
    check("R6 mode off", 32'(codec_mode), 32'd0);
    check("R6 base f40", 32'(codec_base), 32'hF40);
    check("R6 game on", 32'(game_en), 32'd1);
    wr(KEY, ID); wr(16'h0F8D, 8'h10);
    check("R6 base e80", 32'(codec_base), 32'hE80);

    // R8 MIDI register decode
    wr(KEY, ID); wr(16'h0F92, 8'h78);
    check("R8 irq 7", 32'(midi_irq), 32'd7);
    check("R8 base 300", 32'(midi_base), 32'h300);
    wr(KEY, ID); wr(16'h0F92, 8'h28);
    check("R8 irq 10", 32'(midi_irq), 32'd10);
    check("R8 base 320", 32'(midi_base), 32'h320);
    wr(KEY, ID); wr(16'h0F92, 8'h50);
    check("R8 irq 5", 32'(midi_irq), 32'd5);
    check("R8 base 310", 32'(midi_base), 32'h310);

    // R9 forcing sequence with a closed bank at the zero write
    wr(KEY, ID); wr(KEY, 8'hF0);
    legacy_chk("R9 setup", 16'h0220, 2'd3, 4'd5);
    wr(KEY, ID); rd(16'h0F8D); wr(KEY, 8'h00); wr(KEY, ID);
    legacy_chk("R9 kept", 16'h0220, 2'd3, 4'd5);
    rd(KEY);
    check("R9 forced", 32'(host_rdata), 32'h02);

    // R10 outside accesses do not consume the open bank
    wr(KEY, ID);
    rd(16'h0F8C);
    wr(16'h0F93, 8'h77);
    rd(16'h0F8E);
    check("R10 still open", 32'(host_rdata), 32'hA5);
    wr(KEY, ID);
    rd(16'h0F91);
    check("R10 no write", 32'(host_rdata), 32'h3F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule